// File: doc/BRIEF.md
# Delayed Read Bridge with Sequential Prefetch

This block carries a read from a local initiator across to a remote bus. The initiator holds a request with an address until it receives a one-cycle ready strobe. The block claims a read when the address falls inside a fixed window. In that same cycle it stalls the initiator with a not-ready flag and raises its request for the remote bus. Once the remote arbiter grants the bus, the block reads the word at the remapped address. One cycle after that word arrives, it hands the word back with the ready strobe.

When prefetch is switched on for a transaction, the block keeps the remote bus after the demand word. It reads the next few sequential words into a small buffer and then releases the bus. A later read that asks for exactly the next buffered address is answered from the buffer, with no remote traffic. Any other claimed read, and any write seen on the initiator side, discards the buffer.

Top module: `dly_read_bridge`

## Requirements
- R1: A claimed read (address bits [AW-1:WIN_W] equal to LOC_TAG) that is not a buffer hit drives `ini_wait` high in the cycle the request is first seen in idle. `ini_wait` stays high in every cycle the request is held until the cycle of `ini_rdy`, and `ini_rdy` is never high in the cycle after the miss is seen.
- R2: On such a miss, `rem_req` rises in the same cycle as `ini_wait`. It stays high through the grant wait and the demand read.
- R3: `rem_rd` is first driven only in the cycle after `rem_gnt` was seen. `rem_addr` equals the initiator address with bits [AW-1:WIN_W] replaced by REM_TAG and bits [WIN_W-1:0] kept.
- R4: One cycle after the demand word is accepted (`rem_rd` and `rem_rvalid` both high), `ini_rdy` is high for exactly one cycle, `ini_rdata` carries that word, and `ini_wait` is low.
- R5: When `pf_en` is high at the miss, the block reads the PF_DEPTH word addresses that follow the demand address, remapped and in ascending order, after the ready cycle. It keeps `rem_req` high throughout and drops `rem_req` and `rem_rd` in the cycle after the last of these words is accepted.
- R6: A claimed read in idle whose address equals the next buffered address gets `ini_rdy` one cycle later with the buffered word, and `rem_req` stays low. Each hit advances the next buffered address by one, until PF_DEPTH words have been consumed.
- R7: A claimed read that does not match, and a `wr_snoop` pulse in any state, empty the buffer. A snoop during an active prefetch lets the fetch finish but discards its words, so the following read is fetched remotely.
- R8: A read issued while a prefetch is running is held with `ini_wait` and is served after the prefetch ends.
- R9: An unclaimed read produces no `ini_wait`, no `ini_rdy` and no `rem_req`.
- R10: Reset puts the block in idle with the buffer empty, and all outputs are low while no request is present.
- R11: With `pf_en` low at the miss, no word beyond the demand word is fetched, and `rem_req` is low in the ready cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pf_en | input | 1 | Prefetch enable, sampled when a miss is accepted |
| ini_req | input | 1 | Initiator read request, held until `ini_rdy` |
| ini_addr | input | AW | Initiator word address |
| ini_wait | output | 1 | Not-ready indication to the initiator |
| ini_rdy | output | 1 | One-cycle ready strobe completing the read |
| ini_rdata | output | DW | Read data, valid with `ini_rdy` |
| wr_snoop | input | 1 | Pulse marking a write on the initiator side |
| rem_req | output | 1 | Remote bus request |
| rem_gnt | input | 1 | Remote bus grant, held while `rem_req` is high |
| rem_rd | output | 1 | Remote read command, held until `rem_rvalid` |
| rem_addr | output | AW | Remapped remote word address |
| rem_rvalid | input | 1 | Remote data valid; completes the read in that cycle |
| rem_rdata | input | DW | Remote read data |

## Verification
The bench builds the block with a prefetch depth of 3, so the buffer pointer has to wrap at a count that is not a power of two. A short fill also fits quickly between directed reads. The address is 16 bits with a 12-bit window, which keeps remapped addresses easy to predict. Grant and read latencies are varied from zero to two cycles. This reaches same-cycle grants and same-cycle data as well as snoops that land in the middle of a slow prefetch.

// File: rtl/drb_pkg.sv
package drb_pkg;

  typedef enum logic [2:0] {
    ST_IDLE     = 3'd0,
    ST_REQ      = 3'd1,
    ST_READ     = 3'd2,
    ST_PREFETCH = 3'd3,
    ST_RESPOND  = 3'd4
  } drb_state_e;

endpackage

// File: rtl/drb_win.sv
module drb_win #(
  parameter int AW      = 16,
  parameter int WIN_W   = 12,
  parameter int LOC_TAG = 'hE,
  parameter int REM_TAG = 'hA
) (
  input  logic [AW-1:0] probe_addr,
  output logic          claim,
  input  logic [AW-1:0] src_addr,
  output logic [AW-1:0] dst_addr
);

  localparam int TAG_W = AW - WIN_W;
  localparam logic [TAG_W-1:0] LOC_T = TAG_W'(LOC_TAG);
  localparam logic [TAG_W-1:0] REM_T = TAG_W'(REM_TAG);

  // window membership: upper bits select the local aperture
  function automatic logic in_window(input logic [AW-1:0] a);
    return a[AW-1:WIN_W] == LOC_T;
  endfunction

  // aperture remap: swap the tag, keep the offset
  function automatic logic [AW-1:0] remap(input logic [AW-1:0] a);
    return {REM_T, a[WIN_W-1:0]};
  endfunction

  assign claim    = in_window(probe_addr);
  assign dst_addr = remap(src_addr);

endmodule

// File: rtl/drb_pfbuf.sv
module drb_pfbuf #(
  parameter int AW    = 16,
  parameter int DW    = 32,
  parameter int DEPTH = 4,
  parameter int PTR_W = 2,
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             fill_en,
  input  logic [PTR_W-1:0] fill_idx,
  input  logic [DW-1:0]    fill_data,
  input  logic             commit,
  input  logic [AW-1:0]    commit_base,
  input  logic             pop,
  output logic             has_data,
  output logic [AW-1:0]    next_addr,
  output logic [DW-1:0]    head_data
);

  logic [DEPTH-1:0][DW-1:0] slot_w;
  logic [CNT_W-1:0]         left_q;
  logic [PTR_W-1:0]         head_q;
  logic [AW-1:0]            next_q;

  function automatic logic [PTR_W-1:0] next_ptr(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    logic [DW-1:0] word_q;
    always_ff @(posedge clk) begin
      if (fill_en && fill_idx == PTR_W'(i)) word_q <= fill_data;
    end
    assign slot_w[i] = word_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      left_q <= '0;
      head_q <= '0;
      next_q <= '0;
    end else if (clr) begin
      left_q <= '0;
    end else if (commit) begin
      left_q <= CNT_W'(DEPTH);
      head_q <= '0;
      next_q <= commit_base;
    end else if (pop) begin
      left_q <= left_q - CNT_W'(1);
      head_q <= next_ptr(head_q);
      next_q <= next_q + AW'(1);
    end
  end

  assign has_data  = (left_q != '0);
  assign next_addr = next_q;
  assign head_data = slot_w[head_q];

endmodule

// File: rtl/drb_ctrl.sv
module drb_ctrl
  import drb_pkg::*;
#(
  parameter int AW    = 16,
  parameter int DW    = 32,
  parameter int DEPTH = 4,
  parameter int PTR_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pf_en,
  input  logic             ini_req,
  input  logic [AW-1:0]    ini_addr,
  input  logic             claim,
  input  logic             wr_snoop,
  input  logic             buf_has,
  input  logic [AW-1:0]    buf_next,
  input  logic [DW-1:0]    buf_head,
  input  logic             rem_gnt,
  input  logic             rem_rvalid,
  input  logic [DW-1:0]    rem_rdata,
  output logic             ini_wait,
  output logic             ini_rdy,
  output logic [DW-1:0]    ini_rdata,
  output logic             rem_req,
  output logic             rem_rd,
  output logic [AW-1:0]    fetch_src,
  output logic             buf_clr,
  output logic             fill_en,
  output logic [PTR_W-1:0] fill_idx,
  output logic             commit,
  output logic [AW-1:0]    commit_base,
  output logic             pop,
  output logic             st_idle,
  output logic             st_read,
  output logic             st_prefetch,
  output logic             hit_ev,
  output logic             miss_ev,
  output logic             pf_last_ev
);

  localparam logic [PTR_W-1:0] K_LAST = PTR_W'(DEPTH - 1);

  drb_state_e       st_q, st_d;
  logic [AW-1:0]    dem_q;
  logic [PTR_W-1:0] k_q;
  logic             pf_run_q;
  logic             kill_q;
  logic [DW-1:0]    rsp_q;
  logic             st_wgnt, st_resp;

  // address of the sequential word idx+1 past the demand address
  function automatic logic [AW-1:0] seq_addr(input logic [AW-1:0] base,
                                             input logic [PTR_W-1:0] idx);
    return base + AW'(idx) + AW'(1);
  endfunction

  assign st_idle     = (st_q == ST_IDLE);
  assign st_wgnt     = (st_q == ST_REQ);
  assign st_read     = (st_q == ST_READ);
  assign st_prefetch = (st_q == ST_PREFETCH);
  assign st_resp     = (st_q == ST_RESPOND);

  assign hit_ev     = st_idle && ini_req && claim && !wr_snoop && buf_has
                      && (ini_addr == buf_next);
  assign miss_ev    = st_idle && ini_req && claim && !hit_ev;
  assign pf_last_ev = st_prefetch && rem_rvalid && (k_q == K_LAST);

  assign ini_rdy   = st_resp;
  assign ini_rdata = st_resp ? rsp_q : '0;
  assign ini_wait  = ini_req && claim && !st_resp;

  assign rem_req   = miss_ev || st_wgnt || st_read || st_prefetch
                     || (st_resp && pf_run_q);
  assign rem_rd    = st_read || st_prefetch;
  assign fetch_src = st_prefetch ? seq_addr(dem_q, k_q) : dem_q;

  assign buf_clr     = miss_ev || wr_snoop;
  assign fill_en     = st_prefetch && rem_rvalid;
  assign fill_idx    = k_q;
  assign commit      = pf_last_ev && !kill_q && !wr_snoop;
  assign commit_base = seq_addr(dem_q, '0);
  assign pop         = hit_ev;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:     if (hit_ev) st_d = ST_RESPOND;
                   else if (miss_ev) st_d = ST_REQ;
      ST_REQ:      if (rem_gnt) st_d = ST_READ;
      ST_READ:     if (rem_rvalid) st_d = ST_RESPOND;
      ST_RESPOND:  st_d = pf_run_q ? ST_PREFETCH : ST_IDLE;
      ST_PREFETCH: if (pf_last_ev) st_d = ST_IDLE;
      default:     st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      dem_q    <= '0;
      k_q      <= '0;
      pf_run_q <= 1'b0;
      kill_q   <= 1'b0;
      rsp_q    <= '0;
    end else begin
      st_q <= st_d;
      if (miss_ev) begin
        dem_q    <= ini_addr;
        pf_run_q <= pf_en;
        kill_q   <= 1'b0;
      end else begin
        if (wr_snoop && !st_idle) kill_q <= 1'b1;
        if (pf_last_ev) pf_run_q <= 1'b0;
      end
      if (hit_ev) rsp_q <= buf_head;
      else if (st_read && rem_rvalid) begin
        rsp_q <= rem_rdata;
        k_q   <= '0;
      end else if (st_prefetch && rem_rvalid && !pf_last_ev) begin
        k_q <= k_q + PTR_W'(1);
      end
    end
  end

endmodule

// File: rtl/dly_read_bridge.sv
module dly_read_bridge #(
  parameter int AW       = 16,
  parameter int DW       = 32,
  parameter int WIN_W    = 12,
  parameter int LOC_TAG  = 'hE,
  parameter int REM_TAG  = 'hA,
  parameter int PF_DEPTH = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pf_en,
  input  logic          ini_req,
  input  logic [AW-1:0] ini_addr,
  output logic          ini_wait,
  output logic          ini_rdy,
  output logic [DW-1:0] ini_rdata,
  input  logic          wr_snoop,
  output logic          rem_req,
  input  logic          rem_gnt,
  output logic          rem_rd,
  output logic [AW-1:0] rem_addr,
  input  logic          rem_rvalid,
  input  logic [DW-1:0] rem_rdata
);

  localparam int PTR_W = (PF_DEPTH > 1) ? $clog2(PF_DEPTH) : 1;
  localparam int CNT_W = $clog2(PF_DEPTH + 1);

  logic             claim_w;
  logic [AW-1:0]    fetch_src;
  logic             buf_clr, fill_en, commit, pop, buf_has;
  logic [PTR_W-1:0] fill_idx;
  logic [AW-1:0]    commit_base, buf_next;
  logic [DW-1:0]    buf_head;
  logic             st_idle, st_read, st_prefetch;
  logic             hit_ev, miss_ev, pf_last_ev;

  drb_win #(
    .AW(AW), .WIN_W(WIN_W), .LOC_TAG(LOC_TAG), .REM_TAG(REM_TAG)
  ) u_win (
    .probe_addr(ini_addr),
    .claim     (claim_w),
    .src_addr  (fetch_src),
    .dst_addr  (rem_addr)
  );

  drb_ctrl #(
    .AW(AW), .DW(DW), .DEPTH(PF_DEPTH), .PTR_W(PTR_W)
  ) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .pf_en      (pf_en),
    .ini_req    (ini_req),
    .ini_addr   (ini_addr),
    .claim      (claim_w),
    .wr_snoop   (wr_snoop),
    .buf_has    (buf_has),
    .buf_next   (buf_next),
    .buf_head   (buf_head),
    .rem_gnt    (rem_gnt),
    .rem_rvalid (rem_rvalid),
    .rem_rdata  (rem_rdata),
    .ini_wait   (ini_wait),
    .ini_rdy    (ini_rdy),
    .ini_rdata  (ini_rdata),
    .rem_req    (rem_req),
    .rem_rd     (rem_rd),
    .fetch_src  (fetch_src),
    .buf_clr    (buf_clr),
    .fill_en    (fill_en),
    .fill_idx   (fill_idx),
    .commit     (commit),
    .commit_base(commit_base),
    .pop        (pop),
    .st_idle    (st_idle),
    .st_read    (st_read),
    .st_prefetch(st_prefetch),
    .hit_ev     (hit_ev),
    .miss_ev    (miss_ev),
    .pf_last_ev (pf_last_ev)
  );

  drb_pfbuf #(
    .AW(AW), .DW(DW), .DEPTH(PF_DEPTH), .PTR_W(PTR_W), .CNT_W(CNT_W)
  ) u_buf (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr        (buf_clr),
    .fill_en    (fill_en),
    .fill_idx   (fill_idx),
    .fill_data  (rem_rdata),
    .commit     (commit),
    .commit_base(commit_base),
    .pop        (pop),
    .has_data   (buf_has),
    .next_addr  (buf_next),
    .head_data  (buf_head)
  );

endmodule

// File: rtl/drb_chk.sv
module drb_chk #(
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ini_req,
  input logic          ini_wait,
  input logic          ini_rdy,
  input logic [DW-1:0] ini_rdata,
  input logic          rem_req,
  input logic          rem_gnt,
  input logic          rem_rd,
  input logic          rem_rvalid,
  input logic [DW-1:0] rem_rdata,
  input logic          claim_w,
  input logic          st_idle,
  input logic          st_read,
  input logic          hit_ev,
  input logic          miss_ev,
  input logic          pf_last_ev
);

  // R1: data can never be ready in the cycle right after a miss
  a_r1_no_early_rdy: assert property (@(posedge clk) disable iff (!rst_n)
    miss_ev |=> !ini_rdy);

  // R2: remote request accompanies the stall
  a_r2_req_with_wait: assert property (@(posedge clk) disable iff (!rst_n)
    miss_ev |-> (rem_req && ini_wait));

  // R3: a read command starts only after a grant
  a_r3_rd_after_gnt: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rem_rd) |-> $past(rem_gnt));

  // R4: demand word returned the next cycle
  a_r4_rdy_data: assert property (@(posedge clk) disable iff (!rst_n)
    $past(st_read && rem_rvalid) |-> (ini_rdy && ini_rdata == $past(rem_rdata)));

  // R4: ready is a single-cycle strobe
  a_r4_rdy_single: assert property (@(posedge clk) disable iff (!rst_n)
    ini_rdy |=> !ini_rdy);

  // R5: reading stops after the last prefetch word
  a_r5_stop_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    pf_last_ev |=> !rem_rd);

  // R6: a buffer hit completes without the remote bus
  a_r6_hit_local: assert property (@(posedge clk) disable iff (!rst_n)
    hit_ev |=> (ini_rdy && !rem_req));

  // R9: unclaimed reads are invisible
  a_r9_unclaimed_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (st_idle && ini_req && !claim_w) |-> (!rem_req && !ini_wait && !ini_rdy));

endmodule

bind dly_read_bridge drb_chk #(.DW(DW)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .ini_req   (ini_req),
  .ini_wait  (ini_wait),
  .ini_rdy   (ini_rdy),
  .ini_rdata (ini_rdata),
  .rem_req   (rem_req),
  .rem_gnt   (rem_gnt),
  .rem_rd    (rem_rd),
  .rem_rvalid(rem_rvalid),
  .rem_rdata (rem_rdata),
  .claim_w   (claim_w),
  .st_idle   (st_idle),
  .st_read   (st_read),
  .hit_ev    (hit_ev),
  .miss_ev   (miss_ev),
  .pf_last_ev(pf_last_ev)
);

// File: tb/dly_read_bridge_tb_top.sv
module dly_read_bridge_tb_top;

  localparam int AW = 16;
  localparam int DW = 32;
  localparam int DEPTH = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          pf_en = 1'b0;
  logic          ini_req = 1'b0;
  logic [AW-1:0] ini_addr = '0;
  logic          wr_snoop = 1'b0;
  logic          ini_wait, ini_rdy, rem_req, rem_rd, rem_gnt, rem_rvalid;
  logic [DW-1:0] ini_rdata, rem_rdata;
  logic [AW-1:0] rem_addr;

  int tests = 0;
  int fails = 0;
  int cyc = 0;
  int gnt_lat = 0, rd_lat = 0, gnt_cnt = 0, rd_cnt = 0;
  int reqcyc = 0;

  always #4 clk = ~clk;

  dly_read_bridge #(.AW(AW), .DW(DW), .WIN_W(12), .LOC_TAG('hE), .REM_TAG('hA),
                    .PF_DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst_n(rst_n), .pf_en(pf_en), .ini_req(ini_req), .ini_addr(ini_addr),
    .ini_wait(ini_wait), .ini_rdy(ini_rdy), .ini_rdata(ini_rdata), .wr_snoop(wr_snoop),
    .rem_req(rem_req), .rem_gnt(rem_gnt), .rem_rd(rem_rd), .rem_addr(rem_addr),
    .rem_rvalid(rem_rvalid), .rem_rdata(rem_rdata));

  function automatic logic [31:0] word_at(input logic [15:0] a);
    return {a, ~a} ^ 32'h1357_9BDF;
  endfunction
  function automatic logic [15:0] xl(input logic [15:0] a);
    return (a & 16'h0FFF) | 16'hA000;
  endfunction
  function automatic bit inwin(input logic [15:0] a);
    return (a >> 12) == 16'hE;
  endfunction

  // remote responder
  assign rem_gnt    = rem_req && (gnt_cnt >= gnt_lat);
  assign rem_rvalid = rem_rd && (rd_cnt >= rd_lat);
  assign rem_rdata  = word_at(rem_addr);
  always @(posedge clk) begin
    gnt_cnt <= rem_req ? gnt_cnt + 1 : 0;
    rd_cnt  <= (rem_rd && !rem_rvalid) ? rd_cnt + 1 : 0;
  end

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // behavioural reference model: 0 idle, 1 await grant, 2 demand, 3 answer, 4 fill
  int            ph = 0;
  logic [31:0]   m_buf[$];
  logic [31:0]   m_fill[$];
  logic [15:0]   m_next = '0, m_dem = '0;
  int            m_k = 0;
  bit            m_pfon = 0, m_kill = 0;
  logic [31:0]   m_rsp = '0;

  function automatic bit m_hit();
    return ph == 0 && ini_req && inwin(ini_addr) && !wr_snoop &&
           m_buf.size() > 0 && ini_addr == m_next;
  endfunction
  function automatic bit m_miss();
    return ph == 0 && ini_req && inwin(ini_addr) && !m_hit();
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      ph = 0; m_buf.delete(); m_fill.delete(); m_pfon = 0; m_kill = 0; m_k = 0;
    end else begin
      bit h, m;
      h = m_hit();
      m = m_miss();
      if (wr_snoop) begin
        m_buf.delete();
        if (ph != 0) m_kill = 1;
      end
      case (ph)
        0: if (h) begin
             m_rsp = m_buf.pop_front(); m_next = m_next + 16'd1; ph = 3;
           end else if (m) begin
             m_buf.delete(); m_dem = ini_addr; m_pfon = pf_en; m_kill = 0; ph = 1;
           end
        1: if (rem_gnt) ph = 2;
        2: if (rem_rvalid) begin
             m_rsp = word_at(xl(m_dem)); m_k = 0; m_fill.delete(); ph = 3;
           end
        3: ph = m_pfon ? 4 : 0;
        4: if (rem_rvalid) begin
             m_fill.push_back(word_at(xl(m_dem + 16'(m_k) + 16'd1)));
             if (m_k == DEPTH - 1) begin
               if (!m_kill && !wr_snoop) begin
                 m_buf = m_fill; m_next = m_dem + 16'd1;
               end
               m_pfon = 0; ph = 0;
             end else m_k++;
           end
        default: ph = 0;
      endcase
    end
  end

  // per-cycle comparison against the model
  always @(negedge clk) begin
    bit e_wait, e_rdy, e_req, e_rd;
    logic [15:0] e_addr;
    e_rdy  = (ph == 3);
    e_wait = ini_req && inwin(ini_addr) && !e_rdy;
    e_req  = m_miss() || ph == 1 || ph == 2 || ph == 4 || (ph == 3 && m_pfon);
    e_rd   = (ph == 2 || ph == 4);
    e_addr = (ph == 4) ? xl(m_dem + 16'(m_k) + 16'd1) : xl(m_dem);
    if (rem_req) reqcyc++;
    check(ini_wait == e_wait, rst_n ? "R1" : "R10", "ini_wait", 32'(ini_wait), 32'(e_wait));
    check(rem_req == e_req, (ph == 4) ? "R5" : "R2", "rem_req", 32'(rem_req), 32'(e_req));
    check(rem_rd == e_rd, (ph == 4) ? "R5" : "R3", "rem_rd", 32'(rem_rd), 32'(e_rd));
    check(ini_rdy == e_rdy, "R4", "ini_rdy", 32'(ini_rdy), 32'(e_rdy));
    if (e_rd) check(rem_addr == e_addr, (ph == 4) ? "R5" : "R3", "rem_addr",
                    32'(rem_addr), 32'(e_addr));
    if (e_rdy) check(ini_rdata == m_rsp, "R4", "ini_rdata", ini_rdata, m_rsp);
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 100000) begin
      fails++;
      $display("FAIL R10 watchdog expired actual=%0d expected=<100000", cyc);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic do_read(input logic [15:0] a, output logic [31:0] d);
    bit got;
    got = 0;
    d = '0;
    @(posedge clk) #1;
    ini_req = 1'b1; ini_addr = a; reqcyc = 0;
    for (int i = 0; i < 200 && !got; i++) begin
      @(negedge clk);
      if (ini_rdy) begin got = 1; d = ini_rdata; end
    end
    if (!got) check(0, "R4", "no ready", 32'(a), 32'(a));
    @(posedge clk) #1;
    ini_req = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
  endtask

  logic [31:0] d;
  int rq;

  initial begin
    // R10: reset state
    repeat (4) @(negedge clk);
    check(!ini_wait && !ini_rdy && !rem_req && !rem_rd, "R10", "outputs in reset",
          {ini_wait, ini_rdy, rem_req, rem_rd}, 0);
    @(posedge clk) #1 rst_n = 1'b1;
    @(negedge clk);
    check(!ini_wait && !ini_rdy && !rem_req && !rem_rd, "R10", "outputs after reset",
          {ini_wait, ini_rdy, rem_req, rem_rd}, 0);

    // R11: no prefetch, slow grant
    pf_en = 0; gnt_lat = 2; rd_lat = 1;
    do_read(16'hE010, d);
    check(d == word_at(16'hA010), "R4", "demand data", d, word_at(16'hA010));
    idle(5);
    do_read(16'hE011, d);
    check(reqcyc > 0, "R11", "next word fetched remotely", reqcyc, 1);
    check(d == word_at(16'hA011), "R11", "data", d, word_at(16'hA011));
    idle(5);

    // R5 / R6: prefetch then hits, same-cycle grant and data
    pf_en = 1; gnt_lat = 0; rd_lat = 0;
    do_read(16'hE100, d);
    check(d == word_at(16'hA100), "R3", "mapped demand data", d, word_at(16'hA100));
    idle(20);
    for (int i = 1; i <= DEPTH; i++) begin
      logic [15:0] a;
      a = 16'hE100 + 16'(i);
      do_read(a, d);
      check(reqcyc == 0, "R6", "hit used remote bus", reqcyc, 0);
      check(d == word_at(xl(a)), "R6", "buffered data", d, word_at(xl(a)));
    end
    do_read(16'hE100 + 16'(DEPTH + 1), d);
    check(reqcyc > 0, "R6", "drained buffer must miss", reqcyc, 1);
    idle(20);

    // R7: non-matching read invalidates
    rd_lat = 1;
    do_read(16'hE200, d);
    idle(20);
    do_read(16'hE205, d);
    check(reqcyc > 0, "R7", "non-match is a miss", reqcyc, 1);
    idle(20);
    do_read(16'hE201, d);
    check(reqcyc > 0, "R7", "old buffer discarded", reqcyc, 1);
    check(d == word_at(16'hA201), "R7", "data", d, word_at(16'hA201));
    idle(20);

    // R7: snoop after prefetch
    do_read(16'hE300, d);
    idle(20);
    @(posedge clk) #1 wr_snoop = 1'b1;
    @(posedge clk) #1 wr_snoop = 1'b0;
    do_read(16'hE301, d);
    check(reqcyc > 0, "R7", "snoop invalidates", reqcyc, 1);
    idle(20);

    // R7: snoop during prefetch
    rd_lat = 2;
    do_read(16'hE400, d);
    idle(2);
    #1 wr_snoop = 1'b1;
    @(posedge clk) #1 wr_snoop = 1'b0;
    idle(20);
    do_read(16'hE401, d);
    check(reqcyc > 0, "R7", "snoop in prefetch discards", reqcyc, 1);
    idle(20);

    // R8: read issued during prefetch is held then served
    rd_lat = 1; gnt_lat = 1;
    do_read(16'hE500, d);
    do_read(16'hE501, d);
    check(d == word_at(16'hA501), "R8", "held read data", d, word_at(16'hA501));
    check(reqcyc > 0, "R8", "held across prefetch", reqcyc, 1);
    idle(20);

    // R9: unclaimed read ignored
    @(posedge clk) #1;
    ini_req = 1'b1; ini_addr = 16'h3040;
    rq = 0;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      if (ini_wait || ini_rdy || rem_req) rq++;
    end
    check(rq == 0, "R9", "unclaimed activity", rq, 0);
    @(posedge clk) #1 ini_req = 1'b0;
    idle(3);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule